// File: doc/BRIEF.md
# Time-Triggered Node Protocol State Controller

This block holds the protocol state of one node on a time-triggered, slot-scheduled bus. A slot scheduler supplies a pulse at the start of each slot, marks the slots that belong to this node, and pulses at the end of each transmission phase. The controller uses these events to move the node from reset through start-up: a pause, then listening for traffic, then either integration on a frame that a running cluster sends or its own cold start. Once integrated, it decides at each slot the node owns whether the node may send. The decision rests on two checks that run outside the block: the clique test and the blackout test.

The block also exchanges state with the host. It keeps a 2-bit error cause until the host restarts it, and it pulses when the acknowledgment decision for the node's last transmitted frame is final. The host can stop the node at any moment or restart it after a stop. Frame encoding, CRC and membership computation happen elsewhere and reach this block only as status bits.

Top module: `ttc_state_ctrl`

## Requirements
- R1: After synchronous reset the state output is Freeze, err_code is 00, and tx_grant, tx_coldstart, rx_window, agree_req and ack_done are all 0. State codes: Freeze 0, Init 1, Listen 2, ColdStart 3, Passive 4, Active 5.
- R2: In Freeze, host_restart moves the state to Init on the next clock and clears err_code to 00. From Init, the next slot_start moves the state to Listen.
- R3: In Listen or ColdStart, a receive window that closes on tp_end with rx_ok high moves the state to Passive on that clock.
- R4: If Listen sees no good frame, the state moves to ColdStart on the clock of the (2 x SLOTS_PER_ROUND)-th slot_start counted in Listen. It stays in Listen after one fewer.
- R5: In ColdStart, a slot_start with slot_own high gives a one-cycle tx_coldstart pulse and no tx_grant. The state stays ColdStart.
- R6: In Passive or Active, a slot_start with slot_own high and both chk_clique_ok and chk_blackout_ok high moves the state to Active and pulses tx_grant for one cycle. tx_grant is never high outside Active.
- R7: In Passive or Active, a slot_start with slot_own high and a failed check moves the state to Freeze with no tx_grant. err_code is 01 if the clique check failed (this takes priority when both fail), otherwise 10 for a blackout failure.
- R8: In Passive or Active, ack_fail_max moves the state to Freeze with err_code 11.
- R9: host_freeze moves the state to Freeze on the next clock from any state and does not change err_code. While in Freeze, err_code holds until host_restart.
- R10: In Listen, ColdStart, Passive or Active, a slot_start with slot_own low sets rx_window from the next cycle until the cycle after tp_end. When tp_end arrives with rx_ok high in an open window, agree_req pulses for one cycle.
- R11: ack_done pulses for one cycle after ack_decided, but only if a frame has been granted and not yet acknowledged. Otherwise it stays 0.
- R12: host_restart outside Freeze has no effect on the state or err_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | Pulse at the start of a slot |
| slot_own | input | 1 | Qualifies slot_start: slot belongs to this node |
| tp_end | input | 1 | Pulse at the end of the transmission phase |
| rx_ok | input | 1 | With tp_end: frame received correct, with explicit controller state |
| chk_clique_ok | input | 1 | Clique-avoidance check result, valid with own slot_start |
| chk_blackout_ok | input | 1 | Blackout check result, valid with own slot_start |
| ack_decided | input | 1 | Acknowledgment decision for the last sent frame is complete |
| ack_fail_max | input | 1 | Maximum acknowledgment failure count reached |
| host_restart | input | 1 | Host command: restart from Freeze |
| host_freeze | input | 1 | Host command: go to Freeze |
| state | output | 3 | Protocol state code |
| tx_grant | output | 1 | Pulse: send host data frame in this slot |
| tx_coldstart | output | 1 | Pulse: send a cold-start frame in this slot |
| rx_window | output | 1 | Receive window open |
| agree_req | output | 1 | Pulse: forward received frame for state agreement |
| ack_done | output | 1 | Pulse: acknowledgment of last sent frame decided |
| err_code | output | 2 | Held error cause: 01 clique, 10 blackout, 11 ack failure |

## Verification
The bench counts the listen timeout exactly: a timer off by one slot would enter ColdStart one slot early or one slot late. It fails both checks in the same own slot, because a wrong priority would report blackout (10) instead of clique (01). It sends a second ack_decided with no new frame and expects no ack_done, since a tracker that does not clear would pulse twice. It also checks that a restart outside Freeze is ignored and that a host freeze keeps the stored cause, because a design that decodes these commands loosely would move the state or wipe the error code.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  typedef enum logic [2:0] {
    ST_FREEZE = 3'd0,
    ST_INIT   = 3'd1,
    ST_LISTEN = 3'd2,
    ST_COLD   = 3'd3,
    ST_PASSIVE = 3'd4,
    ST_ACTIVE = 3'd5
  } ttc_state_e;

  localparam logic [1:0] ERR_NONE     = 2'b00;
  localparam logic [1:0] ERR_CLIQUE   = 2'b01;
  localparam logic [1:0] ERR_BLACKOUT = 2'b10;
  localparam logic [1:0] ERR_ACKFAIL  = 2'b11;
endpackage

// File: rtl/ttc_listen_timer.sv
module ttc_listen_timer #(
  parameter int SLOTS_PER_ROUND = 8,
  parameter int ROUNDS_TO_WAIT  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic slot_start,
  output logic expire
);
  localparam int LIMIT = SLOTS_PER_ROUND * ROUNDS_TO_WAIT;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expire = enable && slot_start && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt <= '0;
    end else if (slot_start) begin
      if (cnt != CW'(LIMIT - 1))
        cnt <= cnt + 1'b1;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (rst)
    !enable |=> cnt == '0);
endmodule

// File: rtl/ttc_rx_window.sv
module ttc_rx_window (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic flush,
  input  logic tp_end,
  input  logic rx_ok,
  output logic frame_good,
  output logic window_q,
  output logic agree_q
);
  assign frame_good = window_q && tp_end && rx_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      window_q <= 1'b0;
      agree_q  <= 1'b0;
    end else begin
      agree_q <= frame_good;
      if (flush || tp_end)
        window_q <= 1'b0;
      else if (open_req)
        window_q <= 1'b1;
    end
  end

  p_close_on_end_r10: assert property (@(posedge clk) disable iff (rst)
    tp_end |=> !window_q);
  p_agree_needs_window_r10: assert property (@(posedge clk) disable iff (rst)
    agree_q |-> $past(window_q));
endmodule

// File: rtl/ttc_ack_track.sv
module ttc_ack_track (
  input  logic clk,
  input  logic rst,
  input  logic sent,
  input  logic ack_decided,
  input  logic flush,
  output logic ack_done_q
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending    <= 1'b0;
      ack_done_q <= 1'b0;
    end else begin
      ack_done_q <= ack_decided && pending;
      if (sent)
        pending <= 1'b1;
      else if (ack_decided || flush)
        pending <= 1'b0;
    end
  end

  p_ack_cause_r11: assert property (@(posedge clk) disable iff (rst)
    ack_done_q |-> $past(ack_decided));
endmodule

// File: rtl/ttc_state_ctrl.sv
module ttc_state_ctrl
  import ttc_pkg::*;
#(
  parameter int SLOTS_PER_ROUND = 8,
  parameter int LISTEN_ROUNDS   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slot_start,
  input  logic       slot_own,
  input  logic       tp_end,
  input  logic       rx_ok,
  input  logic       chk_clique_ok,
  input  logic       chk_blackout_ok,
  input  logic       ack_decided,
  input  logic       ack_fail_max,
  input  logic       host_restart,
  input  logic       host_freeze,
  output logic [2:0] state,
  output logic       tx_grant,
  output logic       tx_coldstart,
  output logic       rx_window,
  output logic       agree_req,
  output logic       ack_done,
  output logic [1:0] err_code
);
  ttc_state_e state_q, state_d;
  logic [1:0] err_q, err_d;
  logic       grant_q, grant_d;
  logic       cs_q, cs_d;
  logic       expire, frame_good;
  logic       own_evt, synced, rx_open, flush;

  assign own_evt = slot_start && slot_own;
  assign synced  = (state_q == ST_PASSIVE) || (state_q == ST_ACTIVE);
  assign rx_open = slot_start && !slot_own &&
                   (synced || state_q == ST_LISTEN || state_q == ST_COLD);
  assign flush   = (state_q == ST_FREEZE) || (state_q == ST_INIT);

  ttc_listen_timer #(
    .SLOTS_PER_ROUND(SLOTS_PER_ROUND),
    .ROUNDS_TO_WAIT (LISTEN_ROUNDS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .enable    (state_q == ST_LISTEN),
    .slot_start(slot_start),
    .expire    (expire)
  );

  ttc_rx_window u_rxwin (
    .clk       (clk),
    .rst       (rst),
    .open_req  (rx_open),
    .flush     (flush),
    .tp_end    (tp_end),
    .rx_ok     (rx_ok),
    .frame_good(frame_good),
    .window_q  (rx_window),
    .agree_q   (agree_req)
  );

  ttc_ack_track u_ack (
    .clk       (clk),
    .rst       (rst),
    .sent      (grant_d),
    .ack_decided(ack_decided),
    .flush     (state_q == ST_FREEZE),
    .ack_done_q(ack_done)
  );

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    grant_d = 1'b0;
    cs_d    = 1'b0;
    if (host_freeze) begin
      state_d = ST_FREEZE;
    end else begin
      unique case (state_q)
        ST_FREEZE: begin
          if (host_restart) begin
            state_d = ST_INIT;
            err_d   = ERR_NONE;
          end
        end
        ST_INIT: begin
          if (slot_start) state_d = ST_LISTEN;
        end
        ST_LISTEN: begin
          if (frame_good)  state_d = ST_PASSIVE;
          else if (expire) state_d = ST_COLD;
        end
        ST_COLD: begin
          if (frame_good)   state_d = ST_PASSIVE;
          else if (own_evt) cs_d    = 1'b1;
        end
        ST_PASSIVE, ST_ACTIVE: begin
          if (ack_fail_max) begin
            state_d = ST_FREEZE;
            err_d   = ERR_ACKFAIL;
          end else if (own_evt) begin
            if (!chk_clique_ok) begin
              state_d = ST_FREEZE;
              err_d   = ERR_CLIQUE;
            end else if (!chk_blackout_ok) begin
              state_d = ST_FREEZE;
              err_d   = ERR_BLACKOUT;
            end else begin
              state_d = ST_ACTIVE;
              grant_d = 1'b1;
            end
          end
        end
        default: state_d = ST_FREEZE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FREEZE;
      err_q   <= ERR_NONE;
      grant_q <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      grant_q <= grant_d;
      cs_q    <= cs_d;
    end
  end

  assign state        = state_q;
  assign err_code     = err_q;
  assign tx_grant     = grant_q;
  assign tx_coldstart = cs_q;

  p_host_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    host_freeze |=> state_q == ST_FREEZE);
  p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FREEZE && !host_restart) |=> $stable(err_q));
  p_grant_active_r6: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> state_q == ST_ACTIVE);
  p_clique_fail_r7: assert property (@(posedge clk) disable iff (rst)
    (synced && own_evt && !chk_clique_ok && !host_freeze && !ack_fail_max)
      |=> (state_q == ST_FREEZE && err_q == ERR_CLIQUE && !tx_grant));
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FREEZE && host_restart && !host_freeze)
      |=> (state_q == ST_INIT && err_q == ERR_NONE));
  p_cs_only_cold_r5: assert property (@(posedge clk) disable iff (rst)
    tx_coldstart |-> state_q == ST_COLD);
endmodule

// File: tb/sim_ttc_state_ctrl.sv
`timescale 1ns/1ps
module sim_ttc_state_ctrl;
  localparam int SPR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_start = 0, slot_own = 0, tp_end = 0, rx_ok = 0;
  logic chk_clique_ok = 1, chk_blackout_ok = 1;
  logic ack_decided = 0, ack_fail_max = 0, host_restart = 0, host_freeze = 0;
  logic [2:0] state;
  logic tx_grant, tx_coldstart, rx_window, agree_req, ack_done;
  logic [1:0] err_code;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ttc_state_ctrl #(.SLOTS_PER_ROUND(SPR), .LISTEN_ROUNDS(2)) u0 (
    .clk(clk), .rst(rst), .slot_start(slot_start), .slot_own(slot_own),
    .tp_end(tp_end), .rx_ok(rx_ok), .chk_clique_ok(chk_clique_ok),
    .chk_blackout_ok(chk_blackout_ok), .ack_decided(ack_decided),
    .ack_fail_max(ack_fail_max), .host_restart(host_restart),
    .host_freeze(host_freeze), .state(state), .tx_grant(tx_grant),
    .tx_coldstart(tx_coldstart), .rx_window(rx_window), .agree_req(agree_req),
    .ack_done(ack_done), .err_code(err_code));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic slot(input logic own, input logic c_ok, input logic b_ok);
    slot_start = 1; slot_own = own; chk_clique_ok = c_ok; chk_blackout_ok = b_ok;
    tick();
    slot_start = 0; slot_own = 0; chk_clique_ok = 1; chk_blackout_ok = 1;
  endtask

  task automatic end_tp(input logic ok);
    tp_end = 1; rx_ok = ok;
    tick();
    tp_end = 0; rx_ok = 0;
  endtask

  task automatic restart();
    host_restart = 1; tick(); host_restart = 0;
  endtask

  task automatic to_passive();
    restart();
    slot(0, 1, 1);
    slot(0, 1, 1);
    end_tp(1);
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 err", err_code, 0);
    chk("R1 outs", {tx_grant, tx_coldstart, rx_window, agree_req, ack_done}, 0);
  endtask

  task automatic t_startup();
    restart();
    chk("R2 init", state, 1);
    slot(0, 1, 1);
    chk("R2 listen", state, 2);
    slot(0, 1, 1);
    chk("R10 window open", rx_window, 1);
    end_tp(1);
    chk("R3 passive", state, 4);
    chk("R10 agree", agree_req, 1);
    chk("R10 window closed", rx_window, 0);
    ack_decided = 1; tick(); ack_decided = 0;
    chk("R11 no frame sent", ack_done, 0);
  endtask

  task automatic t_active();
    slot(1, 1, 1);
    chk("R6 active", state, 5);
    chk("R6 grant", tx_grant, 1);
    tick();
    chk("R6 grant pulse", tx_grant, 0);
    ack_decided = 1; tick();
    chk("R11 ack done", ack_done, 1);
    tick(); ack_decided = 0;
    chk("R11 second ack", ack_done, 0);
    restart();
    chk("R12 restart ignored", state, 5);
    chk("R12 err kept", err_code, 0);
  endtask

  task automatic t_clique();
    slot(1, 0, 0);
    chk("R7 freeze", state, 0);
    chk("R7 clique code", err_code, 1);
    chk("R7 no grant", tx_grant, 0);
    slot(1, 1, 1);
    tick();
    chk("R9 held state", state, 0);
    chk("R9 held code", err_code, 1);
  endtask

  task automatic t_timeout();
    restart();
    chk("R2 err cleared", err_code, 0);
    slot(0, 1, 1);
    for (int i = 0; i < 2*SPR-1; i++) slot(0, 1, 1);
    chk("R4 still listen", state, 2);
    slot(0, 1, 1);
    chk("R4 coldstart", state, 3);
    slot(1, 1, 1);
    chk("R5 cs pulse", tx_coldstart, 1);
    chk("R5 no grant", tx_grant, 0);
    chk("R5 stay", state, 3);
    slot(0, 1, 1);
    end_tp(1);
    chk("R3 cold to passive", state, 4);
  endtask

  task automatic t_blackout();
    slot(1, 1, 0);
    chk("R7 blackout freeze", state, 0);
    chk("R7 blackout code", err_code, 2);
  endtask

  task automatic t_ackfail();
    to_passive();
    chk("R3 passive again", state, 4);
    ack_fail_max = 1; tick(); ack_fail_max = 0;
    chk("R8 freeze", state, 0);
    chk("R8 code", err_code, 3);
  endtask

  task automatic t_hostfreeze();
    host_freeze = 1; tick(); host_freeze = 0;
    chk("R9 freeze keeps code", err_code, 3);
    restart();
    slot(0, 1, 1);
    chk("R2 listen again", state, 2);
    host_freeze = 1; tick(); host_freeze = 0;
    chk("R9 host freeze", state, 0);
    chk("R9 code unchanged", err_code, 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1;
    tick(); tick();
    rst = 0;
    tick();
    t_reset();
    t_startup();
    t_active();
    t_clique();
    t_timeout();
    t_blackout();
    t_ackfail();
    t_hostfreeze();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule